// File: doc/BRIEF.md
# Descriptor Ring Transmit Queue Engine

This block is the transmit side of one endpoint queue. Software builds a ring of 16-byte descriptors in memory, writes the address of the first one into the block and issues a start command. The engine then handles one descriptor at a time. It reads the descriptor and checks that the hardware-ownership flag is set. It then reads the referenced buffer a word at a time, sends the buffer out as a byte stream with an end-of-packet marker, writes the completion status back into the descriptor and follows that descriptor's link to the next one.

When the engine reaches a descriptor it does not own, it waits on that descriptor and the queue stays active. A resume command makes it read the descriptor's flag word again. Software can skip a descriptor by setting its bypass flag. A zero-length descriptor is sent as an empty packet only when both the global configuration and the descriptor permit it. In every other case the engine raises a length-error interrupt and waits, so software can decide what to do.

Memory is reached through a single-word request/acknowledge port. Control and status go through a small word-addressed register port with a one-cycle read latency.

Top module: `txq_desc_engine`

## Requirements
- R1: A descriptor at byte address A holds four 32-bit words: flags at A, next-descriptor address at A+4, buffer address at A+8, and a length word at A+12 whose low 16 bits are the byte count. Flag bits are: bit0 hardware-owned, bit2 bypass, bit6 empty-packet permitted, bit7 interrupt on completion.
- R2: If the flag word has bit0 clear, the engine waits on that descriptor. The control register then reads active=1 and waiting=1, the current-pointer register keeps the descriptor's address, and no memory write is made.
- R3: A start command loads the current pointer from the start-address register and makes the queue active. A start command given while the queue is already active is ignored.
- R4: The buffer is read as 32-bit words starting from the buffer address rounded down to a word boundary. Bytes go out least significant first under valid/ready handshaking, and `out_last` is set only on the final byte. Data and the marker stay unchanged while `out_ready` is low.
- R5: Once a descriptor is finished, the engine writes word3 with its upper half unchanged and the number of bytes sent in its lower half. It then writes word0 as it was read but with bit0 cleared. It then moves on to the next-descriptor address.
- R6: A descriptor with the bypass bit set sends no bytes. It is completed with a byte count of 0.
- R7: A zero-length descriptor without bypass, where an empty packet is not permitted, sets interrupt-status bit1 (length error). The engine then waits on that descriptor and makes no writes. After software sets bypass and resumes, the descriptor is completed.
- R8: If configuration bit0 is 1 and the descriptor has bit6 set, a zero-length descriptor sends exactly one beat with `out_empty` and `out_last` both set. It is then completed with a count of 0.
- R9: A resume command given while the engine waits makes it fetch word0 of the current descriptor again. If the flag is still clear, the engine goes back to waiting on the same descriptor.
- R10: A stop command clears the active bit on the next clock edge. It abandons any memory access in progress and discards the byte being offered, so `mem_req` and `out_valid` are low after that edge.
- R11: Interrupt-status bit0 (done) is set only when a descriptor with bit7 set completes. Writing a 1 to a status bit clears it. `irq` is the registered OR of the status bits ANDed with the enable register.
- R12: The register map is: 0 start address, 1 control (write bit0 start, bit1 stop, bit2 resume, where stop wins; read bit0 active, bit1 waiting), 2 current pointer, 3 interrupt status, 4 interrupt enable, 5 configuration. After reset all of these read 0, and `irq`, `mem_req` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the beat |
| out_last | output | 1 | Final beat of the packet |
| out_empty | output | 1 | Beat marks an empty packet and carries no data |

## Verification
The assertions check several properties on every clock:
- a stop always sends the walker to idle;
- the current pointer stays fixed while the engine waits;
- a length error always ends in waiting;
- a start from idle loads the start address;
- a stalled byte stays stable;
- a write-one to the done bit clears it.

Other properties can only be shown by the bench's scenarios, which compare every accepted byte and every memory write against a model of the descriptors:
- the byte order and packet-end marking over memory stalls and stream backpressure;
- the order of the writeback to word3 and word0 and its contents;
- the ring walk through bypass, empty-packet and length-error descriptors;
- the re-poll after a resume.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] RA_START = 3'd0;
  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd1;
  localparam logic [REG_AW-1:0] RA_CUR   = 3'd2;
  localparam logic [REG_AW-1:0] RA_ISTAT = 3'd3;
  localparam logic [REG_AW-1:0] RA_IEN   = 3'd4;
  localparam logic [REG_AW-1:0] RA_CFG   = 3'd5;

  // descriptor word offsets in bytes
  localparam int OFF_NEXT = 4;
  localparam int OFF_BUF  = 8;
  localparam int OFF_LEN  = 12;

  // flag bit positions in the first descriptor word
  localparam int F_OWN  = 0;
  localparam int F_SKIP = 2;
  localparam int F_EMPT = 6;
  localparam int F_IRQ  = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3,
    ST_DRD, ST_DWAIT, ST_ZLD, ST_WR3, ST_WR0, ST_PARK
  } walk_st_e;
endpackage

// File: rtl/txq_byte_out.sv
module txq_byte_out #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int NBW = $clog2(NB + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic           load,
  input  logic [DW-1:0]  word,
  input  logic [NBW-1:0] nbytes,
  input  logic           last,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic           out_valid,
  output logic           out_last,
  output logic           out_empty,
  output logic           idle
);
  logic [DW-1:0]  word_q;
  logic [NBW-1:0] cnt_q;
  logic           last_q, empty_q, vld_q;
  logic           final_beat;

  assign final_beat = empty_q || (cnt_q == NBW'(1));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      word_q  <= '0;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      empty_q <= 1'b0;
      vld_q   <= 1'b0;
    end else if (load) begin
      word_q  <= word;
      cnt_q   <= nbytes;
      last_q  <= last;
      empty_q <= (nbytes == '0);
      vld_q   <= 1'b1;
    end else if (vld_q && out_ready) begin
      if (final_beat) begin
        vld_q <= 1'b0;
      end else begin
        word_q <= word_q >> 8;
        cnt_q  <= cnt_q - NBW'(1);
      end
    end
  end

  assign out_data  = empty_q ? 8'h00 : word_q[7:0];
  assign out_valid = vld_q;
  assign out_last  = vld_q && last_q && final_beat;
  assign out_empty = vld_q && empty_q;
  assign idle      = !vld_q;

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush && !load) |=>
      (out_valid && $stable(out_data) && $stable(out_last))); // R4
endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq,
  input  logic [AW-1:0]     cur_ptr,
  input  logic              active,
  input  logic              parked,
  input  logic              done_set,
  input  logic              lenerr_set,
  output logic [AW-1:0]     start_addr,
  output logic              zlp_en,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_resume
);
  logic [AW-1:0] start_q;
  logic [1:0]    istat_q, ien_q, w1c;
  logic          cfg_q;
  logic          ctrl_wr;

  assign ctrl_wr    = reg_we && (reg_addr == RA_CTRL);
  assign cmd_stop   = ctrl_wr && reg_wdata[1];
  assign cmd_start  = ctrl_wr && reg_wdata[0] && !reg_wdata[1];
  assign cmd_resume = ctrl_wr && reg_wdata[2] && !reg_wdata[1];
  assign w1c        = (reg_we && reg_addr == RA_ISTAT) ? reg_wdata[1:0] : 2'b00;
  assign start_addr = start_q;
  assign zlp_en     = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      istat_q   <= '0;
      ien_q     <= '0;
      cfg_q     <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && reg_addr == RA_START) start_q <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == RA_IEN)   ien_q   <= reg_wdata[1:0];
      if (reg_we && reg_addr == RA_CFG)   cfg_q   <= reg_wdata[0];
      istat_q <= (istat_q & ~w1c) | {lenerr_set, done_set};
      irq     <= |(istat_q & ien_q);
      case (reg_addr)
        RA_START: reg_rdata <= REG_DW'(start_q);
        RA_CTRL:  reg_rdata <= REG_DW'({parked, active});
        RA_CUR:   reg_rdata <= REG_DW'(cur_ptr);
        RA_ISTAT: reg_rdata <= REG_DW'(istat_q);
        RA_IEN:   reg_rdata <= REG_DW'(ien_q);
        RA_CFG:   reg_rdata <= REG_DW'(cfg_q);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  AST_DONE_W1C: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_ISTAT && reg_wdata[0] && !done_set) |=> !istat_q[0]); // R11
endmodule

// File: rtl/txq_walker.sv
module txq_walker
  import txq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LENW = 16,
  localparam int NB = DW / 8,
  localparam int NBW = $clog2(NB + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_start,
  input  logic           cmd_stop,
  input  logic           cmd_resume,
  input  logic [AW-1:0]  start_addr,
  input  logic           zlp_en,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           ser_idle,
  output logic           ser_load,
  output logic [DW-1:0]  ser_word,
  output logic [NBW-1:0] ser_nbytes,
  output logic           ser_last,
  output logic [AW-1:0]  cur_ptr,
  output logic           active,
  output logic           parked,
  output logic           done_set,
  output logic           lenerr_set
);
  walk_st_e       state_q;
  logic [AW-1:0]  cur_q, next_q, buf_q, baddr_q;
  logic [DW-1:0]  w0_q, w3_q;
  logic [LENW-1:0] rem_q, cnt_q, rd_len;
  logic [NBW-1:0] chunk;
  logic           len_zero, empty_ok;

  assign rd_len   = mem_rdata[LENW-1:0];
  assign len_zero = (rd_len == '0);
  assign empty_ok = zlp_en && w0_q[F_EMPT];
  assign chunk    = (rem_q >= LENW'(NB)) ? NBW'(NB) : NBW'(rem_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      next_q  <= '0;
      buf_q   <= '0;
      baddr_q <= '0;
      w0_q    <= '0;
      w3_q    <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
    end else if (cmd_stop) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_start) begin
          cur_q   <= start_addr;
          state_q <= ST_RD0;
        end
        ST_RD0: if (mem_ack) begin
          w0_q    <= mem_rdata;
          state_q <= mem_rdata[F_OWN] ? ST_RD1 : ST_PARK;
        end
        ST_RD1: if (mem_ack) begin
          next_q  <= mem_rdata[AW-1:0];
          state_q <= ST_RD2;
        end
        ST_RD2: if (mem_ack) begin
          buf_q   <= mem_rdata[AW-1:0];
          state_q <= ST_RD3;
        end
        ST_RD3: if (mem_ack) begin
          w3_q <= mem_rdata;
          if (w0_q[F_SKIP]) begin
            cnt_q   <= '0;
            state_q <= ST_WR3;
          end else if (len_zero) begin
            cnt_q   <= '0;
            rem_q   <= '0;
            state_q <= empty_ok ? ST_ZLD : ST_PARK;
          end else begin
            cnt_q   <= rd_len;
            rem_q   <= rd_len;
            baddr_q <= buf_q & ~AW'(NB - 1);
            state_q <= ST_DRD;
          end
        end
        ST_DRD: if (mem_ack) begin
          rem_q   <= rem_q - LENW'(chunk);
          baddr_q <= baddr_q + AW'(NB);
          state_q <= ST_DWAIT;
        end
        ST_ZLD: state_q <= ST_DWAIT;
        ST_DWAIT: if (ser_idle) state_q <= (rem_q == '0) ? ST_WR3 : ST_DRD;
        ST_WR3: if (mem_ack) state_q <= ST_WR0;
        ST_WR0: if (mem_ack) begin
          cur_q   <= next_q;
          state_q <= ST_RD0;
        end
        ST_PARK: if (cmd_resume) state_q <= ST_RD0;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    case (state_q)
      ST_RD0: mem_addr = cur_q;
      ST_RD1: mem_addr = cur_q + AW'(OFF_NEXT);
      ST_RD2: mem_addr = cur_q + AW'(OFF_BUF);
      ST_RD3: mem_addr = cur_q + AW'(OFF_LEN);
      ST_DRD: mem_addr = baddr_q;
      ST_WR3: begin
        mem_we    = 1'b1;
        mem_addr  = cur_q + AW'(OFF_LEN);
        mem_wdata = {w3_q[DW-1:LENW], cnt_q};
      end
      ST_WR0: begin
        mem_we    = 1'b1;
        mem_wdata = w0_q & ~(DW'(1) << F_OWN);
      end
      default: mem_req = 1'b0;
    endcase
  end

  always_comb begin
    ser_word   = mem_rdata;
    ser_nbytes = chunk;
    ser_last   = (rem_q <= LENW'(NB));
    ser_load   = (state_q == ST_DRD) && mem_ack && !cmd_stop;
    if (state_q == ST_ZLD && !cmd_stop) begin
      ser_load   = 1'b1;
      ser_nbytes = '0;
      ser_last   = 1'b1;
    end
  end

  assign cur_ptr    = cur_q;
  assign active     = (state_q != ST_IDLE);
  assign parked     = (state_q == ST_PARK);
  assign done_set   = (state_q == ST_WR0) && mem_ack && w0_q[F_IRQ] && !cmd_stop;
  assign lenerr_set = (state_q == ST_RD3) && mem_ack && !w0_q[F_SKIP] &&
                      len_zero && !empty_ok && !cmd_stop;

  AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_stop |=> (state_q == ST_IDLE)); // R10
  AST_PARK_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PARK) |=> $stable(cur_q)); // R2
  AST_LENERR_PARKS: assert property (@(posedge clk) disable iff (rst)
    lenerr_set |=> (state_q == ST_PARK)); // R7
  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && cmd_start && !cmd_stop) |=> (cur_q == $past(start_addr))); // R3
endmodule

// File: rtl/txq_desc_engine.sv
module txq_desc_engine
  import txq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LENW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic              out_empty
);
  localparam int NBW = $clog2(DW / 8 + 1);

  logic [AW-1:0]  start_addr, cur_ptr;
  logic           zlp_en, cmd_start, cmd_stop, cmd_resume;
  logic           active, parked, done_set, lenerr_set;
  logic           ser_idle, ser_load, ser_last;
  logic [DW-1:0]  ser_word;
  logic [NBW-1:0] ser_nbytes;

  txq_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .cur_ptr(cur_ptr), .active(active), .parked(parked),
    .done_set(done_set), .lenerr_set(lenerr_set),
    .start_addr(start_addr), .zlp_en(zlp_en),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_resume(cmd_resume)
  );

  txq_walker #(.AW(AW), .DW(DW), .LENW(LENW)) u_walker (
    .clk(clk), .rst(rst),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_resume(cmd_resume),
    .start_addr(start_addr), .zlp_en(zlp_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ser_idle(ser_idle), .ser_load(ser_load), .ser_word(ser_word),
    .ser_nbytes(ser_nbytes), .ser_last(ser_last),
    .cur_ptr(cur_ptr), .active(active), .parked(parked),
    .done_set(done_set), .lenerr_set(lenerr_set)
  );

  txq_byte_out #(.DW(DW)) u_bytes (
    .clk(clk), .rst(rst), .flush(cmd_stop),
    .load(ser_load), .word(ser_word), .nbytes(ser_nbytes), .last(ser_last),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last), .out_empty(out_empty), .idle(ser_idle)
  );
endmodule

// File: tb/txq_desc_engine_test.sv
module txq_desc_engine_test;
  localparam logic [2:0] A_START = 3'd0, A_CTRL = 3'd1, A_CUR = 3'd2,
                         A_ISTAT = 3'd3, A_IEN = 3'd4, A_CFG = 3'd5;
  localparam int D0 = 32'h100;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0]  out_data;
  logic        out_valid, out_ready = 1'b1, out_last, out_empty;

  logic [31:0] mem [0:255];
  logic [9:0]  exp_b[$];
  logic [63:0] exp_w[$];
  int checks = 0, errors = 0, cyc = 0, ready_mode = 0;
  bit stall_en = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  txq_desc_engine uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_empty(out_empty)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory and sink model, driven just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    mem_ack = mem_req && !rst && !(stall_en && (cyc % 3 == 1));
    if (mem_ack && mem_we) mem[mem_addr[9:2]] = mem_wdata;
    mem_rdata = mem[mem_addr[9:2]];
    out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;
  end

  // reference comparison on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) begin
        if (exp_b.size() == 0) chk("R4 unexpected beat", {54'd0, out_empty, out_last, out_data}, 64'h3ff);
        else chk("R4 beat", {54'd0, out_empty, out_last, out_data}, {54'd0, exp_b.pop_front()});
      end
      if (mem_req && mem_we && mem_ack) begin
        if (exp_w.size() == 0) chk("R5 unexpected write", {mem_addr, mem_wdata}, 64'hffffffffffffffff);
        else chk("R5 writeback (R1 layout)", {mem_addr, mem_wdata}, exp_w.pop_front());
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic put_desc(input int a, input logic [31:0] f, input int nxt, input int ba, input int len);
    mem[a >> 2] = f; mem[(a >> 2) + 1] = nxt; mem[(a >> 2) + 2] = ba;
    mem[(a >> 2) + 3] = {16'hA5C3, 16'(len)};
  endtask

  task automatic exp_desc(input int a, input bit zlp);
    logic [31:0] f, w3, bw;
    int len, ba, cnt;
    f = mem[a >> 2]; ba = mem[(a >> 2) + 2]; w3 = mem[(a >> 2) + 3];
    len = int'(w3[15:0]); cnt = 0;
    if (!f[2]) begin
      if (len == 0) begin
        if (!(zlp && f[6])) return;
        exp_b.push_back(10'h300);
      end else begin
        for (int i = 0; i < len; i++) begin
          bw = mem[((ba & ~3) >> 2) + i / 4];
          exp_b.push_back({1'b0, logic'(i == len - 1), bw[8 * (i % 4) +: 8]});
        end
        cnt = len;
      end
    end
    exp_w.push_back({32'(a + 12), w3[31:16], 16'(cnt)});
    exp_w.push_back({32'(a), f & ~32'h1});
  endtask

  task automatic wait_parked(input string tag);
    logic [31:0] d;
    int n = 0;
    do begin rd(A_CTRL, d); n++; end while (!d[1] && n < 400);
    chk(tag, 64'(d[1:0]), 64'd3);
    chk(tag, 64'(exp_b.size()), 64'd0);
    chk(tag, 64'(exp_w.size()), 64'd0);
  endtask

  function automatic int da(input int i);
    return D0 + 16 * i;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 256; k++) mem[k] = {8'(k + 3), 8'(k * 7), 8'(k + 1), 8'(k)};
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R12 reset values
    rd(A_START, d); chk("R12 start reset", 64'(d), 0);
    rd(A_CTRL, d);  chk("R12 ctrl reset", 64'(d), 0);
    rd(A_CUR, d);   chk("R12 cur reset", 64'(d), 0);
    rd(A_ISTAT, d); chk("R12 istat reset", 64'(d), 0);
    chk("R12 irq/req/valid reset", {61'd0, irq, mem_req, out_valid}, 0);

    // R4 R5 R11 R2: two descriptors then a not-owned one, with stalls and backpressure
    stall_en = 1'b1; ready_mode = 1;
    put_desc(da(0), 32'h81, da(1), 32'h200, 5);
    put_desc(da(1), 32'h01, da(2), 32'h242, 8);
    put_desc(da(2), 32'h00, da(3), 32'h280, 3);
    exp_desc(da(0), 0); exp_desc(da(1), 0);
    wr(A_START, da(0)); wr(A_IEN, 1); wr(A_CTRL, 1);
    wait_parked("R2 park on unowned");
    rd(A_CUR, d);   chk("R2 pointer on unowned", 64'(d), 64'(da(2)));
    rd(A_ISTAT, d); chk("R11 done after IOC", 64'(d), 1);
    chk("R11 irq raised", 64'(irq), 1);
    wr(A_ISTAT, 1);
    rd(A_ISTAT, d); chk("R11 done W1C", 64'(d), 0);
    chk("R11 irq cleared", 64'(irq), 0);

    // R3: start while active is ignored
    wr(A_START, da(0)); wr(A_CTRL, 1);
    rd(A_CUR, d); chk("R3 start ignored when active", 64'(d), 64'(da(2)));

    // R9: resume with ownership still clear re-parks in place
    wr(A_CTRL, 4);
    repeat (12) @(posedge clk);
    wait_parked("R9 re-park");
    rd(A_CUR, d); chk("R9 same pointer", 64'(d), 64'(da(2)));

    // R9 R11: owned now, resume completes it (no IOC -> no done)
    put_desc(da(2), 32'h01, da(3), 32'h280, 3);
    put_desc(da(3), 32'h00, da(4), 32'h2C0, 4);
    exp_desc(da(2), 0);
    wr(A_CTRL, 4);
    wait_parked("R9 resume proceeds");
    rd(A_CUR, d);   chk("R9 advanced", 64'(d), 64'(da(3)));
    rd(A_ISTAT, d); chk("R11 no done without IOC", 64'(d), 0);

    // R6: bypass, sink always ready so any beat is caught
    ready_mode = 0; stall_en = 1'b0;
    put_desc(da(3), 32'h85, da(4), 32'h2C0, 4);
    put_desc(da(4), 32'h00, da(5), 0, 0);
    exp_desc(da(3), 0);
    wr(A_CTRL, 4);
    wait_parked("R6 bypass");
    rd(A_CUR, d); chk("R6 advanced past bypass", 64'(d), 64'(da(4)));
    wr(A_ISTAT, 3);

    // R7: zero length, empty packets not enabled
    put_desc(da(4), 32'hC1, da(5), 0, 0);
    put_desc(da(5), 32'h00, da(6), 0, 0);
    wr(A_IEN, 3); wr(A_CTRL, 4);
    wait_parked("R7 length-error park");
    rd(A_CUR, d);   chk("R7 pointer held", 64'(d), 64'(da(4)));
    rd(A_ISTAT, d); chk("R7 length error bit", 64'(d), 2);
    chk("R7 irq", 64'(irq), 1);
    wr(A_ISTAT, 2);
    mem[da(4) >> 2] = 32'hC5;
    exp_desc(da(4), 0);
    wr(A_CTRL, 4);
    wait_parked("R7 bypass after error");
    rd(A_CUR, d);   chk("R7 advanced", 64'(d), 64'(da(5)));
    rd(A_ISTAT, d); chk("R7 done only", 64'(d), 1);
    wr(A_ISTAT, 3);

    // R8: empty packet enabled
    put_desc(da(5), 32'h41, da(6), 0, 0);
    put_desc(da(6), 32'h00, da(7), 0, 0);
    wr(A_CFG, 1);
    exp_desc(da(5), 1);
    wr(A_CTRL, 4);
    wait_parked("R8 empty packet");
    rd(A_CUR, d);   chk("R8 advanced", 64'(d), 64'(da(6)));
    rd(A_ISTAT, d); chk("R8 no length error", 64'(d[1]), 0);

    // R10: stop while a byte is stuck under backpressure
    ready_mode = 2;
    put_desc(da(6), 32'h01, da(7), 32'h300, 12);
    wr(A_CTRL, 4);
    for (int n = 0; n < 200 && !out_valid; n++) begin @(posedge clk); #1; end
    chk("R10 byte offered", 64'(out_valid), 1);
    wr(A_CTRL, 2);
    chk("R10 stream and memory drop", {62'd0, out_valid, mem_req}, 0);
    rd(A_CTRL, d); chk("R10 inactive", 64'(d), 0);
    ready_mode = 0;

    // R3: fresh start loads the start address
    put_desc(da(8), 32'h00, da(0), 0, 0);
    wr(A_START, da(8)); wr(A_CTRL, 1);
    wait_parked("R3 start");
    rd(A_CUR, d); chk("R3 pointer loaded", 64'(d), 64'(da(8)));

    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule